// File: doc/BRIEF.md
# Far-End Fault Pattern Generator and Link Monitor

This block sits between the MAC-side transmit bit stream and the serial code-bit stream of a 100 Mbps fiber port, with one bit per clock in each direction. When the local receiver reports loss of signal and fault signalling is enabled, it stops the MAC data and sends a repeating fault pattern. Each period of the pattern is a run of ones closed by a single zero. When the fault ends, the pattern period in progress is completed before normal traffic resumes.

On the receive side, the block searches the incoming code bits for the same pattern and raises a remote-fault flag. It also qualifies the link. The link comes up only after a run of idle symbols has been counted on a clean line. It goes down on a local or remote fault, unless a forced-link input holds it up. A drop of the link sets a sticky interrupt.

Transmit states: `TX_NORMAL` (data or idle ones pass), `TX_FAULT` (pattern sent while the fault lasts), `TX_DRAIN` (fault gone, finishing the period). Transitions: NORMAL→FAULT on a fault request; FAULT→DRAIN when the request ends mid-period; FAULT→NORMAL or DRAIN→NORMAL on the closing zero with no request; DRAIN→FAULT when the request returns. Receive monitor states: `RM_CLEAR`, `RM_TRACK` (at least one match counted), `RM_FAULT`. Transitions: CLEAR→TRACK on a match; TRACK→FAULT on the third consecutive match; TRACK→CLEAR or FAULT→CLEAR when a full period passes without a match. Link states: `LK_DOWN`, `LK_QUAL` (counting idles), `LK_UP`. Transitions: DOWN→QUAL on a clean idle; QUAL→UP on the last required idle; QUAL→DOWN on any fault; UP→DOWN on a fault when not forced.

Top module: `far_fault_link`

## Requirements
- R1: While a fault request (`fault_tx_en`=1 and `sig_det`=0) lasts, `tx_bit` repeats an 85-bit period of 84 ones followed by one zero, and `tx_fault_active` is 1.
- R2: While `tx_fault_active` is 1, `tx_data_bit` and `tx_data_valid` have no effect on `tx_bit`.
- R3: A fault request sampled at a clock edge makes the first pattern bit (a one) appear on `tx_bit` in the next cycle.
- R4: With `fault_tx_en`=0, no pattern is sent even when `sig_det`=0. `tx_bit` equals `tx_data_bit` when `tx_data_valid`=1 and is the idle value 1 otherwise.
- R5: When the fault request ends, the current period runs to its closing zero, and normal traffic appears in the cycle after that zero.
- R6: A match is a received zero that follows exactly 84 ones. `remote_fault` rises at the edge that samples the third consecutive match, and not before.
- R7: `remote_fault` stays set for 84 received bits after the last match and clears at the edge of the 85th non-matching bit.
- R8: `link_up` rises at the edge that samples the 16th `rx_idle` strobe counted while `sig_det`=1 and `remote_fault`=0. A fault during counting restarts the count. Strobes seen while a fault is present are not counted, so a line whose first signal is the fault pattern never brings the link up.
- R9: With `force_link`=0, a local fault (`sig_det`=0) or `remote_fault`=1 sampled while the link is up clears `link_up` in the next cycle.
- R10: With `force_link`=1, an established link stays up through local and remote faults.
- R11: `link_irq` is set in the cycle after `link_up` falls and stays set until `irq_ack` is sampled high. A new drop wins over an acknowledge in the same cycle.
- R12: During reset, `link_up`, `link_irq`, `remote_fault` and `tx_fault_active` are 0, and `tx_bit` follows the normal path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_tx_en | input | 1 | Enables fault pattern transmission |
| sig_det | input | 1 | Local signal detect, 0 means fault |
| force_link | input | 1 | Holds an established link up |
| tx_data_valid | input | 1 | MAC-side bit is valid |
| tx_data_bit | input | 1 | MAC-side transmit bit |
| tx_bit | output | 1 | Transmit code bit |
| tx_fault_active | output | 1 | Pattern period in progress |
| rx_bit | input | 1 | Received code bit |
| rx_idle | input | 1 | One idle symbol received (strobe) |
| remote_fault | output | 1 | Far-end fault detected |
| link_up | output | 1 | Link status |
| irq_ack | input | 1 | Clears the link-down interrupt |
| link_irq | output | 1 | Sticky link-down interrupt |

## Verification
The bench releases the fault request in the middle of a period and checks that the zero still arrives on bit 84 before data resumes. A generator that cut the period short would put data into the middle of a pattern. It counts idle strobes to exactly one short of the threshold, both from reset and after a fault that interrupts counting, so an off-by-one or a counter that is not cleared shows up as an early link. On the receive side it checks the remote flag after the second and after the third match, and on each side of the 85-bit clear window, so a wrong repetition count or a wrong window length shows up. It also checks that idles sent while only the fault pattern has been seen never bring the link up, and that a forced link rides through both kinds of fault.

// File: rtl/fefl_pkg.sv
package fefl_pkg;

    typedef enum logic [1:0] {
        TX_NORMAL,
        TX_FAULT,
        TX_DRAIN
    } tx_state_t;

    typedef enum logic [1:0] {
        RM_CLEAR,
        RM_TRACK,
        RM_FAULT
    } rm_state_t;

    typedef enum logic [1:0] {
        LK_DOWN,
        LK_QUAL,
        LK_UP
    } lk_state_t;

endpackage

// File: rtl/fefl_tx_gen.sv
module fefl_tx_gen
    import fefl_pkg::*;
#(
    parameter int PAT_ONES = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_req,
    input  logic data_valid,
    input  logic data_bit,
    output logic tx_bit,
    output logic fault_active
);
    localparam int PAT_LEN = PAT_ONES + 1;
    localparam int CW      = $clog2(PAT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(PAT_LEN - 1);

    tx_state_t       state, nxt;
    logic [CW-1:0]   bit_cnt;
    logic            at_last;

    assign at_last = (bit_cnt == LAST);

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            TX_NORMAL: if (fault_req) nxt = TX_FAULT;
            TX_FAULT: begin
                if (!fault_req && at_last)  nxt = TX_NORMAL;
                else if (!fault_req)        nxt = TX_DRAIN;
            end
            TX_DRAIN: begin
                if (fault_req)              nxt = TX_FAULT;
                else if (at_last)           nxt = TX_NORMAL;
            end
            default:                        nxt = TX_NORMAL;
        endcase
    end

    // state register and position in the period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_NORMAL;
            bit_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == TX_NORMAL || at_last)
                bit_cnt <= '0;
            else
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            TX_FAULT, TX_DRAIN: begin
                tx_bit       = !at_last;
                fault_active = 1'b1;
            end
            default: begin
                tx_bit       = data_valid ? data_bit : 1'b1;
                fault_active = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fefl_rx_mon.sv
module fefl_rx_mon
    import fefl_pkg::*;
#(
    parameter int PAT_ONES   = 84,
    parameter int MATCH_REPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    output logic remote_fault
);
    localparam int PAT_LEN = PAT_ONES + 1;
    localparam int RW      = $clog2(PAT_ONES + 2);
    localparam int GW      = $clog2(PAT_LEN + 1);
    localparam int MW      = $clog2(MATCH_REPS + 1);
    localparam logic [RW-1:0] RUN_SAT  = RW'(PAT_ONES + 1);
    localparam logic [RW-1:0] RUN_HIT  = RW'(PAT_ONES);
    localparam logic [GW-1:0] GAP_END  = GW'(PAT_LEN - 1);
    localparam logic [MW-1:0] REP_LAST = MW'(MATCH_REPS - 1);

    rm_state_t      state, nxt;
    logic [RW-1:0]  run_cnt;
    logic [GW-1:0]  gap_cnt;
    logic [MW-1:0]  reps;
    logic           match, expired;

    assign match   = !rx_bit && (run_cnt == RUN_HIT);
    assign expired = !match && (gap_cnt == GAP_END);

    always_comb begin
        nxt = state;
        unique case (state)
            RM_CLEAR: if (match) nxt = RM_TRACK;
            RM_TRACK: begin
                if (match && reps == REP_LAST) nxt = RM_FAULT;
                else if (expired)              nxt = RM_CLEAR;
            end
            RM_FAULT: if (expired) nxt = RM_CLEAR;
            default:  nxt = RM_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RM_CLEAR;
            run_cnt <= RUN_SAT;
            gap_cnt <= GAP_END;
            reps    <= '0;
        end else begin
            state <= nxt;
            // length of the current run of ones
            if (rx_bit)
                run_cnt <= (run_cnt == RUN_SAT) ? run_cnt : run_cnt + 1'b1;
            else
                run_cnt <= '0;
            // bits since the last match
            if (match)
                gap_cnt <= '0;
            else if (!expired)
                gap_cnt <= gap_cnt + 1'b1;
            // consecutive matches
            if (nxt == RM_CLEAR)
                reps <= '0;
            else if (match && reps != REP_LAST + 1'b1)
                reps <= reps + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            RM_FAULT: remote_fault = 1'b1;
            default:  remote_fault = 1'b0;
        endcase
    end

endmodule

// File: rtl/fefl_link_fsm.sv
module fefl_link_fsm
    import fefl_pkg::*;
#(
    parameter int IDLE_NEED = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_det,
    input  logic remote_fault,
    input  logic rx_idle,
    input  logic force_link,
    input  logic irq_ack,
    output logic link_up,
    output logic link_irq
);
    localparam int IW = $clog2(IDLE_NEED + 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_NEED - 1);

    lk_state_t      state, nxt;
    logic [IW-1:0]  idle_cnt;
    logic           line_fault, clean_idle;

    assign line_fault = !sig_det || remote_fault;
    assign clean_idle = rx_idle && !line_fault;

    always_comb begin
        nxt = state;
        unique case (state)
            LK_DOWN: begin
                if (clean_idle) nxt = (IDLE_NEED <= 1) ? LK_UP : LK_QUAL;
            end
            LK_QUAL: begin
                if (line_fault)                             nxt = LK_DOWN;
                else if (clean_idle && idle_cnt == IDLE_LAST) nxt = LK_UP;
            end
            LK_UP: if (line_fault && !force_link) nxt = LK_DOWN;
            default: nxt = LK_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LK_DOWN;
            idle_cnt <= '0;
            link_irq <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != LK_QUAL)
                idle_cnt <= (nxt == LK_DOWN || state == LK_UP) ? '0 : idle_cnt;
            if (nxt == LK_DOWN)
                idle_cnt <= '0;
            else if (clean_idle && state != LK_UP)
                idle_cnt <= idle_cnt + 1'b1;
            // sticky interrupt: a new drop wins over an acknowledge
            if (state == LK_UP && nxt != LK_UP)
                link_irq <= 1'b1;
            else if (irq_ack)
                link_irq <= 1'b0;
        end
    end

    always_comb begin
        unique case (state)
            LK_UP:   link_up = 1'b1;
            default: link_up = 1'b0;
        endcase
    end

endmodule

// File: rtl/far_fault_link.sv
module far_fault_link #(
    parameter int PAT_ONES   = 84,
    parameter int MATCH_REPS = 3,
    parameter int IDLE_NEED  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_tx_en,
    input  logic sig_det,
    input  logic force_link,
    input  logic tx_data_valid,
    input  logic tx_data_bit,
    output logic tx_bit,
    output logic tx_fault_active,
    input  logic rx_bit,
    input  logic rx_idle,
    output logic remote_fault,
    output logic link_up,
    input  logic irq_ack,
    output logic link_irq
);
    logic fault_req;

    assign fault_req = fault_tx_en && !sig_det;

    fefl_tx_gen #(.PAT_ONES(PAT_ONES)) tx_gen_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_req    (fault_req),
        .data_valid   (tx_data_valid),
        .data_bit     (tx_data_bit),
        .tx_bit       (tx_bit),
        .fault_active (tx_fault_active)
    );

    fefl_rx_mon #(.PAT_ONES(PAT_ONES), .MATCH_REPS(MATCH_REPS)) rx_mon_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_bit       (rx_bit),
        .remote_fault (remote_fault)
    );

    fefl_link_fsm #(.IDLE_NEED(IDLE_NEED)) link_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sig_det      (sig_det),
        .remote_fault (remote_fault),
        .rx_idle      (rx_idle),
        .force_link   (force_link),
        .irq_ack      (irq_ack),
        .link_up      (link_up),
        .link_irq     (link_irq)
    );

endmodule

// File: rtl/far_fault_link_chk.sv
module far_fault_link_chk (
    input logic clk,
    input logic rst_n,
    input logic fault_tx_en,
    input logic sig_det,
    input logic force_link,
    input logic tx_bit,
    input logic tx_fault_active,
    input logic rx_bit,
    input logic remote_fault,
    input logic link_up,
    input logic link_irq
);
    // R1: the closing zero of a period is followed by a new leading one while the request lasts
    p_zero_then_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fault_active && !tx_bit && fault_tx_en && !sig_det) |=> (tx_fault_active && tx_bit));

    // R3: a request seen in normal mode starts the pattern in the next cycle
    p_fault_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_tx_en && !sig_det && !tx_fault_active) |=> (tx_fault_active && tx_bit));

    // R4: disabled signalling never starts a pattern
    p_no_fault_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_tx_en && !tx_fault_active) |=> !tx_fault_active);

    // R6: the remote flag only rises after a received zero
    p_remote_on_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(remote_fault) |-> !$past(rx_bit));

    // R8: link only rises on a clean line
    p_link_needs_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> ($past(sig_det) && !$past(remote_fault)));

    // R9: unforced local fault drops the link
    p_drop_on_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !force_link && !sig_det) |=> !link_up);

    // R10: forced link holds
    p_force_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && force_link) |=> link_up);

    // R11: a drop raises the interrupt
    p_irq_on_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_up) |-> link_irq);

endmodule

bind far_fault_link far_fault_link_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .fault_tx_en     (fault_tx_en),
    .sig_det         (sig_det),
    .force_link      (force_link),
    .tx_bit          (tx_bit),
    .tx_fault_active (tx_fault_active),
    .rx_bit          (rx_bit),
    .remote_fault    (remote_fault),
    .link_up         (link_up),
    .link_irq        (link_irq)
);

// File: tb/far_fault_link_tb_top.sv
module far_fault_link_tb_top;

    logic clk = 1'b0;
    logic rst_n, fault_tx_en, sig_det, force_link, tx_data_valid, tx_data_bit;
    logic rx_bit, rx_idle, irq_ack;
    logic tx_bit, tx_fault_active, remote_fault, link_up, link_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    far_fault_link dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .fault_tx_en     (fault_tx_en),
        .sig_det         (sig_det),
        .force_link      (force_link),
        .tx_data_valid   (tx_data_valid),
        .tx_data_bit     (tx_data_bit),
        .tx_bit          (tx_bit),
        .tx_fault_active (tx_fault_active),
        .rx_bit          (rx_bit),
        .rx_idle         (rx_idle),
        .remote_fault    (remote_fault),
        .link_up         (link_up),
        .irq_ack         (irq_ack),
        .link_irq        (link_irq)
    );

    // fields: en, sig_det, valid, data, expected tx_bit, expected active
    localparam logic [5:0] VEC [0:7] = '{
        6'b001000, 6'b001110, 6'b000010, 6'b011000,
        6'b111000, 6'b111110, 6'b110010, 6'b000110
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rx_bit = b;
        step();
    endtask

    task automatic send_pattern();
        for (int k = 0; k < 84; k++) send_bit(1'b1);
        send_bit(1'b0);
    endtask

    task automatic idle_n(input int n);
        rx_idle = 1'b1;
        repeat (n) step();
        rx_idle = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int mism;
        rst_n = 1'b0; fault_tx_en = 1'b0; sig_det = 1'b1; force_link = 1'b0;
        tx_data_valid = 1'b0; tx_data_bit = 1'b0; rx_bit = 1'b1; rx_idle = 1'b0;
        irq_ack = 1'b0;
        repeat (3) step();
        // R12 reset state
        chk("R12 link_up", link_up, 0);
        chk("R12 link_irq", link_irq, 0);
        chk("R12 remote_fault", remote_fault, 0);
        chk("R12 tx_fault_active", tx_fault_active, 0);
        chk("R12 tx_bit idle", tx_bit, 1);
        rst_n = 1'b1;
        step();

        // R4 vector table on the normal path
        for (int v = 0; v < 8; v++) begin
            {fault_tx_en, sig_det, tx_data_valid, tx_data_bit} = VEC[v][5:2];
            #1;
            chk("R4 vector tx_bit", tx_bit, VEC[v][1]);
            chk("R4 vector active", tx_fault_active, VEC[v][0]);
            step();
        end
        fault_tx_en = 1'b0; sig_det = 1'b1; tx_data_valid = 1'b0;

        // R6/R7/R8: fault pattern first, idles during fault ignored
        send_bit(1'b0);
        send_pattern();
        send_pattern();
        chk("R6 not after two matches", remote_fault, 0);
        send_pattern();
        chk("R6 set on third match", remote_fault, 1);
        rx_idle = 1'b1;
        send_pattern();
        send_pattern();
        rx_idle = 1'b0;
        chk("R8 idles during fault ignored", link_up, 0);
        for (int k = 0; k < 84; k++) send_bit(1'b1);
        chk("R7 held for 84 bits", remote_fault, 1);
        send_bit(1'b1);
        chk("R7 cleared at bit 85", remote_fault, 0);

        // R8 qualification threshold
        idle_n(15);
        chk("R8 down after 15 idles", link_up, 0);
        idle_n(1);
        chk("R8 up after 16 idles", link_up, 1);

        // R9/R11 drop on local loss, sticky interrupt
        sig_det = 1'b0;
        step();
        chk("R9 drop on local loss", link_up, 0);
        chk("R11 irq set", link_irq, 1);
        sig_det = 1'b1;
        step();
        chk("R11 irq sticky", link_irq, 1);
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        chk("R11 irq cleared by ack", link_irq, 0);

        // R8 count restarts after fault during qualification
        idle_n(10);
        sig_det = 1'b0;
        step();
        sig_det = 1'b1;
        idle_n(15);
        chk("R8 restart: down after 15", link_up, 0);
        chk("R11 no irq while qualifying", link_irq, 0);
        idle_n(1);
        chk("R8 restart: up after 16", link_up, 1);

        // R10 forced link through local and remote faults
        force_link = 1'b1;
        sig_det = 1'b0;
        repeat (5) step();
        chk("R10 forced through local loss", link_up, 1);
        send_bit(1'b0);
        send_pattern(); send_pattern(); send_pattern();
        chk("R10 remote seen", remote_fault, 1);
        chk("R10 forced through remote fault", link_up, 1);
        chk("R10 no irq", link_irq, 0);
        force_link = 1'b0;
        step();
        chk("R9 drop once force released", link_up, 0);
        sig_det = 1'b1;
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;

        // R9 drop on remote fault alone, one cycle after the flag
        for (int k = 0; k < 85; k++) send_bit(1'b1);
        idle_n(16);
        chk("R8 up again", link_up, 1);
        send_bit(1'b0);
        send_pattern(); send_pattern(); send_pattern();
        chk("R9 remote raised", remote_fault, 1);
        chk("R9 link one cycle later", link_up, 1);
        step();
        chk("R9 drop on remote fault", link_up, 0);
        rx_bit = 1'b1;

        // R1/R2/R3/R5 pattern generation, release mid-period
        fault_tx_en = 1'b1; sig_det = 1'b0; tx_data_valid = 1'b1; tx_data_bit = 1'b0;
        #1;
        chk("R3 not active before edge", tx_fault_active, 0);
        step();
        chk("R3 first bit is one", tx_bit, 1);
        mism = 0;
        for (int i = 0; i < 255; i++) begin
            if (tx_bit !== ((i % 85 == 84) ? 1'b0 : 1'b1)) mism++;
            if (tx_fault_active !== 1'b1) mism++;
            if (i == 180) sig_det = 1'b1;
            step();
        end
        chk("R1 R2 R5 pattern mismatches", mism, 0);
        chk("R5 data after closing zero", tx_bit, 0);
        chk("R5 inactive after period", tx_fault_active, 0);

        // R4 disabled signalling with loss of signal
        fault_tx_en = 1'b0; sig_det = 1'b0;
        mism = 0;
        for (int i = 0; i < 100; i++) begin
            tx_data_bit = i[0];
            #1;
            if (tx_fault_active !== 1'b0 || tx_bit !== i[0]) mism++;
            step();
        end
        chk("R4 no pattern when disabled", mism, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule